// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter with eight multiplexed analog inputs. A conversion begins on a software start pulse or on an internal trigger pulse. At that moment the sequencer captures the input channel and the clock divide setting. It then tests one result bit per conversion-clock period, starting at the most significant bit. For each trial it drives a code to the capacitor DAC and reads back one comparator bit. The conversion clock is a prescaled form of the system clock, with a divide ratio of 4, 8, 16 or 32.

When the last bit is decided, the full result is written to the result register in one update and an interrupt flag is raised. The sequencer then either goes idle (single mode) or starts the next conversion at once (continuous mode). The interrupt flag stays set until software clears it.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The result is found from the most significant bit down. Each conversion begins with trial code 0x200 on `dac_code`. For a steady input level V in the range 0 to 1023, the final result equals V.
- R2: Each trial bit is decided at the end of one conversion-clock period. The bit is kept when `cmp_in` is 1 (input at or above the DAC level) and cleared when it is 0. The next lower bit is then set as the new trial.
- R3: `cfg_div` selects the system clocks per bit decision: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. One conversion therefore lasts 10 times that count. The field is sampled only when a conversion starts.
- R4: `mux_sel` takes `cfg_chan` when a conversion starts. A change of `cfg_chan` during a conversion has no effect until the next conversion.
- R5: A one-cycle pulse on `sw_start` or `trig_start` starts a conversion only while the block is idle. Such pulses are ignored while busy.
- R6: `busy` rises on the clock edge that accepts a start. In single mode it falls on the edge that latches the result.
- R7: `result` changes only on the edge of the final bit decision, and all 10 bits change together.
- R8: `irq` is set at the end of every conversion and stays set until `irq_clr` is pulsed. If the set and the clear fall in the same cycle, the set wins.
- R9: If `cfg_cont` is 1 at the final decision, a new conversion starts on that same edge and samples channel and divider afresh. If `cfg_cont` is cleared during a conversion, that conversion completes and the block then stops.
- R10: After a synchronous reset, `busy`, `irq`, `result`, `dac_code` and `mux_sel` are all zero.
- R11: While idle, `dac_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chan | input | 3 | Channel to convert, sampled at start |
| cfg_div | input | 2 | Conversion clock divide select, sampled at start |
| cfg_cont | input | 1 | Continuous mode enable |
| sw_start | input | 1 | Software start pulse |
| trig_start | input | 1 | Internal trigger start pulse |
| irq_clr | input | 1 | Clears the interrupt flag |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Trial code to the capacitor DAC |
| mux_sel | output | 3 | Analog input multiplexer select |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed conversion result |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
Two events can fall in the same cycle: the interrupt being set at the final bit decision, and a software clear of the flag. The bench provokes this by watching its own reference model for the cycle just before the last decision, and driving `irq_clr` in exactly that cycle. It then expects the flag to be set afterwards. In the same way, start pulses are placed mid-conversion and channel changes are made while busy. This checks that neither affects the running conversion, because the model is compared with every output on every clock.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned RES_W_DEF     = 10;
  localparam int unsigned CH_W_DEF      = 3;
  localparam int unsigned DIV_W_DEF     = 2;
  localparam int unsigned BASE_LOG2_DEF = 2;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sar_seq_prescale.sv
module sar_seq_prescale #(
  parameter int unsigned DIV_W     = 2,
  parameter int unsigned BASE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             reload,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned NUM_RATIO = 1 << DIV_W;
  localparam int unsigned MAX_LOG2  = BASE_LOG2 + NUM_RATIO - 1;
  localparam int unsigned CNT_W     = MAX_LOG2;

  logic [CNT_W-1:0] lim_tab [NUM_RATIO];
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  // terminal count per ratio: (2^(BASE_LOG2+g)) - 1
  for (genvar g = 0; g < NUM_RATIO; g++) begin : g_lim
    assign lim_tab[g] = {CNT_W{1'b1}} >> (MAX_LOG2 - BASE_LOG2 - g);
  end

  assign tick = run && (cnt_q == lim_tab[div_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (reload) begin
      cnt_q <= '0;
      div_q <= div_sel;
    end else if (tick) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_seq_search.sv
module sar_seq_search #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic             step,
  input  logic             cmp_hit,
  output logic [RES_W-1:0] code,
  output logic             last,
  output logic [RES_W-1:0] final_code
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] mask_q;
  logic [RES_W-1:0] decided;

  // per-bit decision: the bit under trial follows the comparator
  for (genvar b = 0; b < RES_W; b++) begin : g_bit
    assign decided[b] = mask_q[b] ? cmp_hit : code_q[b];
  end

  assign code       = code_q;
  assign last       = step && mask_q[0];
  assign final_code = decided;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      code_q <= TOP_BIT;
      mask_q <= TOP_BIT;
    end else if (clear) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (step) begin
      code_q <= decided | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_seq_report.sv
module sar_seq_report #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [RES_W-1:0] final_code,
  input  logic             irq_clr,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (done) begin
      result <= final_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (done) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W     = RES_W_DEF,
  parameter int unsigned CH_W      = CH_W_DEF,
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned BASE_LOG2 = BASE_LOG2_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cont,
  input  logic             sw_start,
  input  logic             trig_start,
  input  logic             irq_clr,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  mux_sel,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  seq_state_t       state_q;
  logic [CH_W-1:0]  chan_q;
  logic             start_ok;
  logic             tick;
  logic             step;
  logic             conv_done;
  logic             rearm;
  logic             halt;
  logic             load;
  logic [RES_W-1:0] final_code;

  assign start_ok = (state_q == SEQ_IDLE) && (sw_start || trig_start);
  assign step     = tick && (state_q == SEQ_CONV);
  assign rearm    = conv_done && cfg_cont;
  assign halt     = conv_done && !cfg_cont;
  assign load     = start_ok || rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else if (start_ok) begin
      state_q <= SEQ_CONV;
    end else if (halt) begin
      state_q <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
    end else if (load) begin
      chan_q <= cfg_chan;
    end
  end

  sar_seq_prescale #(
    .DIV_W     (DIV_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == SEQ_CONV),
    .reload  (load),
    .div_sel (cfg_div),
    .tick    (tick)
  );

  sar_seq_search #(
    .RES_W (RES_W)
  ) u_search (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .clear      (halt),
    .step       (step),
    .cmp_hit    (cmp_in),
    .code       (dac_code),
    .last       (conv_done),
    .final_code (final_code)
  );

  sar_seq_report #(
    .RES_W (RES_W)
  ) u_report (
    .clk        (clk),
    .rst        (rst),
    .done       (conv_done),
    .final_code (final_code),
    .irq_clr    (irq_clr),
    .result     (result),
    .irq        (irq)
  );

  assign mux_sel = chan_q;
  assign busy    = (state_q == SEQ_CONV);
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             irq,
  input logic             irq_clr,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] dac_code,
  input logic [CH_W-1:0]  mux_sel,
  input logic             done
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  a_r1_msb_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (dac_code == TOP_BIT));

  a_r4_sel_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(mux_sel));

  a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result));

  a_r8_irq_on_done: assert property (@(posedge clk) disable iff (rst)
    done |=> irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  a_r11_idle_dac_zero: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0));

  a_r6_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

bind sar_seq_ctrl sar_seq_checker #(
  .RES_W (RES_W),
  .CH_W  (CH_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .irq      (irq),
  .irq_clr  (irq_clr),
  .result   (result),
  .dac_code (dac_code),
  .mux_sel  (mux_sel),
  .done     (conv_done)
);

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_chan = '0;
  logic [1:0] cfg_div = '0;
  logic       cfg_cont = 1'b0;
  logic       sw_start = 1'b0;
  logic       trig_start = 1'b0;
  logic       irq_clr = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [2:0] mux_sel;
  logic       busy;
  logic [9:0] result;
  logic       irq;

  logic [9:0] vin [8];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // analog model: comparator against per-channel level
  assign cmp_in = (vin[mux_sel] >= dac_code);

  sar_seq_ctrl dut (
    .clk(clk), .rst(rst), .cfg_chan(cfg_chan), .cfg_div(cfg_div),
    .cfg_cont(cfg_cont), .sw_start(sw_start), .trig_start(trig_start),
    .irq_clr(irq_clr), .cmp_in(cmp_in), .dac_code(dac_code),
    .mux_sel(mux_sel), .busy(busy), .result(result), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_armed = 1'b0;
  bit         m_busy = 1'b0;
  bit         m_irq = 1'b0;
  int         m_cnt = 0;
  int         m_lim = 4;
  int         m_bit = 0;
  int         m_sel = 0;
  int         m_code = 0;
  int         m_res = 0;
  int         m_expect = 0;
  bit         m_just_done = 1'b0;
  int         done_cnt = 0;
  bit         t_cmp, t_tick, t_start, t_done;
  int         t_new;

  wire m_done_next = m_busy && (m_cnt == m_lim - 1) && (m_bit == 0);

  always @(posedge clk) begin
    cyc++;
    m_armed = 1'b1;
    m_just_done = 1'b0;
    if (rst) begin
      m_busy = 0; m_irq = 0; m_cnt = 0; m_lim = 4; m_bit = 0;
      m_sel = 0; m_code = 0; m_res = 0;
    end else begin
      t_cmp   = (int'(vin[m_sel]) >= m_code);
      t_tick  = m_busy && (m_cnt == m_lim - 1);
      t_start = !m_busy && (sw_start || trig_start);
      t_done  = t_tick && (m_bit == 0);
      if (t_done) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (t_start) begin
        m_busy = 1; m_sel = int'(cfg_chan); m_lim = 4 << cfg_div;
        m_cnt = 0; m_code = 512; m_bit = 9;
      end else if (t_tick) begin
        t_new = t_cmp ? m_code : (m_code & ~(1 << m_bit));
        if (m_bit == 0) begin
          m_res = t_new;
          m_expect = int'(vin[m_sel]);
          m_just_done = 1'b1;
          done_cnt++;
          if (cfg_cont) begin
            m_sel = int'(cfg_chan); m_lim = 4 << cfg_div;
            m_cnt = 0; m_code = 512; m_bit = 9;
          end else begin
            m_busy = 0; m_code = 0; m_cnt = 0;
          end
        end else begin
          m_code = t_new | (1 << (m_bit - 1));
          m_bit--;
          m_cnt = 0;
        end
      end else if (m_busy) begin
        m_cnt++;
      end
    end
    if (cyc > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (m_armed && !rst) begin
      chk(busy === m_busy, "R6 busy", int'(busy), int'(m_busy));
      chk(dac_code === m_code[9:0], "R2 dac_code", int'(dac_code), m_code);
      chk(mux_sel === m_sel[2:0], "R4 mux_sel", int'(mux_sel), m_sel);
      chk(result === m_res[9:0], "R7 result", int'(result), m_res);
      chk(irq === m_irq, "R8 irq", int'(irq), int'(m_irq));
      if (m_just_done)
        chk(int'(result) == m_expect, "R1 result equals input level", int'(result), m_expect);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_start(input bit use_trig);
    @(negedge clk);
    if (use_trig) trig_start = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    trig_start = 1'b0; sw_start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic run_single(input int ch, input int dv, input int level, input bit use_trig);
    int n;
    vin[ch] = level[9:0];
    cfg_chan = ch[2:0]; cfg_div = dv[1:0]; cfg_cont = 1'b0;
    pulse_start(use_trig);
    n = 0;
    while (busy === 1'b1) begin @(negedge clk); n++; end
    chk(n == 10 * (4 << dv), "R3 conversion length", n, 10 * (4 << dv));
    chk(result == level[9:0], "R1 final result", int'(result), level);
    chk(irq === 1'b1, "R8 irq after conversion", int'(irq), 1);
    chk(dac_code == 10'd0, "R11 idle dac_code", int'(dac_code), 0);
    if (use_trig) chk(n > 0, "R5 trigger start", n, 1);
    pulse_clr();
  endtask

  initial begin
    int n, base;
    for (int i = 0; i < 8; i++) vin[i] = 10'(i * 97);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0, "R10 busy", int'(busy), 0);
    chk(irq === 1'b0, "R10 irq", int'(irq), 0);
    chk(result === 10'd0, "R10 result", int'(result), 0);
    chk(dac_code === 10'd0, "R10 dac_code", int'(dac_code), 0);
    chk(mux_sel === 3'd0, "R10 mux_sel", int'(mux_sel), 0);

    // R1 R2 R3 across dividers, channels and edge levels
    run_single(0, 0, 10'h2A5, 1'b0);
    run_single(3, 1, 0, 1'b0);
    run_single(5, 2, 1023, 1'b0);
    run_single(7, 3, 512, 1'b0);
    run_single(2, 0, 511, 1'b0);
    run_single(1, 1, 1, 1'b0);
    // R5 internal trigger
    run_single(4, 0, 10'h155, 1'b1);

    // R5 starts while busy are ignored
    vin[6] = 10'd100; cfg_chan = 3'd6; cfg_div = 2'd0;
    pulse_start(1'b0);
    repeat (5) @(negedge clk);
    sw_start = 1'b1; trig_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; trig_start = 1'b0;
    // R4 channel change while busy has no effect
    vin[0] = 10'h2A5; cfg_chan = 3'd0;
    n = 6;
    while (busy === 1'b1) begin @(negedge clk); n++; end
    chk(n == 40, "R5 ignored start keeps length", n, 40);
    chk(result == 10'd100, "R4 old channel converted", int'(result), 100);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R5 no restart from ignored pulse", int'(busy), 0);
    pulse_clr();
    chk(irq === 1'b0, "R8 cleared by irq_clr", int'(irq), 0);

    // R8 set and clear in the same cycle: set wins
    cfg_chan = 3'd3; vin[3] = 10'h0C3;
    pulse_start(1'b0);
    while (!m_done_next) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq === 1'b1, "R8 set wins over clear", int'(irq), 1);
    pulse_clr();

    // R9 continuous mode, channel re-sampled, cleared mid-run
    vin[2] = 10'h0F0; vin[5] = 10'h30C;
    cfg_chan = 3'd2; cfg_div = 2'd1; cfg_cont = 1'b1;
    base = done_cnt;
    pulse_start(1'b0);
    while (done_cnt == base) @(negedge clk);
    chk(busy === 1'b1, "R9 restarts after result", int'(busy), 1);
    chk(result == 10'h0F0, "R9 first result", int'(result), 10'h0F0);
    cfg_chan = 3'd5; cfg_div = 2'd0;
    while (done_cnt == base + 1) @(negedge clk);
    chk(mux_sel == 3'd5, "R9 new channel sampled", int'(mux_sel), 5);
    repeat (10) @(negedge clk);
    cfg_cont = 1'b0;
    while (busy === 1'b1) @(negedge clk);
    chk(done_cnt - base == 3, "R9 running conversion finishes", done_cnt - base, 3);
    chk(result == 10'h30C, "R9 last result", int'(result), 10'h30C);
    repeat (5) @(negedge clk);
    chk(busy === 1'b0, "R9 stays stopped", int'(busy), 0);

    finish_run();
  end
endmodule